// File: doc/BRIEF.md
# Serial Master for an Eight-Channel Switch Driver with Fault Decoding

This block is the controller side of the serial link to an eight-channel protected high-side switch. A single strobe starts one exchange. The block pulls the active-low write/select line low and waits a fixed setup time. It then runs eight clock cycles with the clock idling high. Command bits go out on the data output, and the switch's pin-state bits are read back on the data input. Raising the write line at the end commits the new command inside the switch.

Each bit read back shows whether a channel output pin was high or low during the frame. That pin state reflects the command committed at the end of the previous frame. The block compares each pin state with that earlier command and reports a two-bit fault code per channel. When every channel disagrees with its command at once, the block reports a single over-temperature flag and no per-channel faults.

The clock half-period is set in system clocks by an input. It is clamped from below so that the serial clock never runs faster than the slave allows.

Top module: `drv_link_master`

## Requirements
- R1: After reset, and at all times while not busy, `wr_o` and `sclk_o` are high. After reset `busy_o`, `done_o` and `valid_o` are low.
- R2: The first falling edge of `sclk_o` comes exactly SETUP_CYC system clocks after `wr_o` falls.
- R3: Each low phase and each high phase of `sclk_o` within a frame lasts H system clocks. H is `half_div_i` sampled at start, raised to MIN_HALF if it is smaller.
- R4: `din_o` changes only when `sclk_o` falls. A slave that samples on rising edges receives `cmd_i` bit 0 (channel 1) first and bit 7 last.
- R5: `dout_i` is captured at each rising edge of `sclk_o`. The k-th captured bit appears at `diag_o[k]`.
- R6: A frame has exactly eight rising clock edges. `wr_o` rises one half-period after the eighth rising edge, with `sclk_o` still high. `done_o` is high for exactly the one cycle in which `wr_o` rises, and the result outputs take their new values in that same cycle.
- R7: `fault_o[2k+1:2k]` holds the code for channel k, judged against the previous frame's command. The code is 0 when the pin matches the command, 1 when the command was on and the pin reads low (short to ground), and 2 when the command was off and the pin reads high (short to supply or open load).
- R8: When all eight channels are faulty, `thermal_o` is 1 and `fault_o` is all zero.
- R9: After the first frame following reset, `valid_o` is 0, and `fault_o` and `thermal_o` are zero. After every later frame, `valid_o` is 1.
- R10: `start_i` has no effect while `busy_o` is high. The command sent stays the one latched at start, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame when idle |
| cmd_i | input | 8 | Channel command word, bit 0 = channel 1 |
| half_div_i | input | 8 | Serial clock half-period in system clocks |
| wr_o | output | 1 | Write/select line, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial command data to the slave |
| dout_i | input | 1 | Serial pin-state data from the slave |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| diag_o | output | 8 | Pin states read in the last frame |
| fault_o | output | 16 | Two-bit fault code per channel |
| thermal_o | output | 1 | All channels faulty at once |
| valid_o | output | 1 | Fault outputs are judged against a real prior command |

## Verification
A wrong phase or bit counter appears directly on the pins. It shows as a shortened or stretched clock phase, a ninth or seventh clock edge, or a select line that rises early. All of these are visible within one frame of a few thousand system clocks. A corrupted stored command is invisible in the frame where it happens. It shows up only one frame later, as wrong fault codes or a false over-temperature flag. The bench therefore runs consecutive frames and compares each result with the command it sent one frame earlier.

// File: rtl/drv_link_pkg.sv
package drv_link_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GND    = 2'd1,
    FLT_SUPPLY = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_LOW,
    S_HIGH
  } seq_e;
endpackage

// File: rtl/drv_link_seq.sv
module drv_link_seq
  import drv_link_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int DIV_W     = 8,
  parameter int SETUP_CYC = 375,
  parameter int MIN_HALF  = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NCH-1:0]   cmd_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             dout_i,
  output logic             wr_o,
  output logic             sclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             end_stb_o,
  output logic             done_o,
  output logic [NCH-1:0]   rx_o,
  output logic [NCH-1:0]   sent_o
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW    = $clog2(SETUP_CYC + 1);
  localparam logic [DIV_W-1:0] HMIN  = DIV_W'(MIN_HALF);
  localparam logic [SW-1:0]    SLAST = SW'(SETUP_CYC - 1);
  localparam logic [IDX_W-1:0] ILAST = IDX_W'(NCH - 1);

  seq_e             state;
  logic [DIV_W-1:0] cnt, half_q, half_eff;
  logic [SW-1:0]    scnt;
  logic [IDX_W-1:0] idx;
  logic [NCH-1:0]   sh;
  logic             phase_end;

  assign half_eff  = (half_div_i < HMIN) ? HMIN : half_div_i;
  assign phase_end = (cnt == half_q - 1'b1);
  assign busy_o    = (state != S_IDLE);
  assign end_stb_o = (state == S_HIGH) && phase_end && (idx == ILAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_IDLE;
      wr_o   <= 1'b1;
      sclk_o <= 1'b1;
      din_o  <= 1'b0;
      cnt    <= '0;
      scnt   <= '0;
      idx    <= '0;
      sh     <= '0;
      rx_o   <= '0;
      sent_o <= '0;
      half_q <= HMIN;
      done_o <= 1'b0;
    end else begin
      done_o <= end_stb_o;
      unique case (state)
        S_IDLE: if (start_i) begin
          sent_o <= cmd_i;
          sh     <= cmd_i;
          half_q <= half_eff;
          scnt   <= '0;
          wr_o   <= 1'b0;
          state  <= S_SETUP;
        end
        S_SETUP: begin
          if (scnt == SLAST) begin
            sclk_o <= 1'b0;
            din_o  <= sh[0];
            sh     <= sh >> 1;
            idx    <= '0;
            cnt    <= '0;
            state  <= S_LOW;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        S_LOW: begin
          if (phase_end) begin
            sclk_o    <= 1'b1;
            rx_o[idx] <= dout_i;
            cnt       <= '0;
            state     <= S_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (phase_end) begin
            cnt <= '0;
            if (idx == ILAST) begin
              wr_o  <= 1'b1;
              state <= S_IDLE;
            end else begin
              sclk_o <= 1'b0;
              din_o  <= sh[0];
              sh     <= sh >> 1;
              idx    <= idx + 1'b1;
              state  <= S_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drv_link_classify.sv
module drv_link_classify
  import drv_link_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_stb_i,
  input  logic [NCH-1:0]   rx_i,
  input  logic [NCH-1:0]   sent_i,
  output logic [NCH-1:0]   diag_o,
  output logic [2*NCH-1:0] fault_o,
  output logic             thermal_o,
  output logic             valid_o
);
  logic [NCH-1:0]   prev_cmd, bad;
  logic [2*NCH-1:0] codes;
  logic             have_prev, all_bad;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    flt_e code;
    always_comb begin
      if (prev_cmd[k] && !rx_i[k])      code = FLT_GND;
      else if (!prev_cmd[k] && rx_i[k]) code = FLT_SUPPLY;
      else                              code = FLT_NONE;
    end
    assign bad[k]         = (code != FLT_NONE);
    assign codes[2*k +: 2] = code;
  end

  assign all_bad = &bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cmd  <= '0;
      have_prev <= 1'b0;
      diag_o    <= '0;
      fault_o   <= '0;
      thermal_o <= 1'b0;
      valid_o   <= 1'b0;
    end else if (end_stb_i) begin
      diag_o    <= rx_i;
      valid_o   <= have_prev;
      thermal_o <= have_prev && all_bad;
      fault_o   <= (have_prev && !all_bad) ? codes : '0;
      prev_cmd  <= sent_i;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/drv_link_master.sv
module drv_link_master #(
  parameter int NCH       = 8,
  parameter int DIV_W     = 8,
  parameter int SETUP_CYC = 375,
  parameter int MIN_HALF  = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NCH-1:0]   cmd_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             wr_o,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NCH-1:0]   diag_o,
  output logic [2*NCH-1:0] fault_o,
  output logic             thermal_o,
  output logic             valid_o
);
  logic           end_stb;
  logic [NCH-1:0] rx, sent;

  drv_link_seq #(
    .NCH(NCH), .DIV_W(DIV_W), .SETUP_CYC(SETUP_CYC), .MIN_HALF(MIN_HALF)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .half_div_i(half_div_i), .dout_i(dout_i), .wr_o(wr_o), .sclk_o(sclk_o),
    .din_o(din_o), .busy_o(busy_o), .end_stb_o(end_stb), .done_o(done_o),
    .rx_o(rx), .sent_o(sent)
  );

  drv_link_classify #(.NCH(NCH)) u_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .end_stb_i(end_stb), .rx_i(rx),
    .sent_i(sent), .diag_o(diag_o), .fault_o(fault_o),
    .thermal_o(thermal_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/drv_link_master_chk.sv
module drv_link_master_chk #(
  parameter int NCH       = 8,
  parameter int SETUP_CYC = 375,
  parameter int MIN_HALF  = 125
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_o,
  input logic             sclk_o,
  input logic             din_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [2*NCH-1:0] fault_o,
  input logic             thermal_o,
  input logic             valid_o
);
  logic [15:0] wr_low_cnt, run_cnt;
  logic        sclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_low_cnt <= '0;
      run_cnt    <= '0;
      sclk_prev  <= 1'b1;
    end else begin
      sclk_prev  <= sclk_o;
      wr_low_cnt <= wr_o ? '0 : ((&wr_low_cnt) ? wr_low_cnt : wr_low_cnt + 1'b1);
      if (sclk_o != sclk_prev) run_cnt <= 16'd1;
      else if (!(&run_cnt))    run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1
  idle_lines_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (wr_o && sclk_o));

  // R2
  setup_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (wr_low_cnt >= 16'(SETUP_CYC)));

  // R3
  low_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (run_cnt >= 16'(MIN_HALF)));

  // R4
  din_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(din_o) |-> $fell(sclk_o));

  // R6
  done_with_wr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(wr_o) && sclk_o));

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  thermal_clears_codes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_o |-> (fault_o == '0 && valid_o));

  // R9
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!thermal_o && fault_o == '0));
endmodule

bind drv_link_master drv_link_master_chk #(
  .NCH(NCH), .SETUP_CYC(SETUP_CYC), .MIN_HALF(MIN_HALF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_o(wr_o), .sclk_o(sclk_o),
  .din_o(din_o), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
  .thermal_o(thermal_o), .valid_o(valid_o)
);

// File: tb/drv_link_master_tb.sv
module drv_link_master_tb;
  localparam int SETUP = 375;
  localparam int HMIN  = 125;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [7:0]  half_div_i = '0;
  logic        wr_o, sclk_o, din_o, dout_i, busy_o, done_o, thermal_o, valid_o;
  logic [7:0]  diag_o;
  logic [15:0] fault_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] pin_vec = '0, sl_out = '0, sl_in = '0, sl_cmd = '0;
  int         sl_ptr = 0;
  logic [7:0] exp_prev = '0;
  bit         exp_have = 1'b0;
  int         meas_s, meas_h;

  always #4 clk_i = ~clk_i;

  drv_link_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .half_div_i(half_div_i), .wr_o(wr_o), .sclk_o(sclk_o), .din_o(din_o),
    .dout_i(dout_i), .busy_o(busy_o), .done_o(done_o), .diag_o(diag_o),
    .fault_o(fault_o), .thermal_o(thermal_o), .valid_o(valid_o)
  );

  // slave model: loads pin states at select, samples and shifts on rising CLK
  always @(negedge wr_o) begin sl_out = pin_vec; sl_ptr = 0; end
  always @(posedge sclk_o) if (wr_o === 1'b0 && sl_ptr < 8) begin
    sl_in[sl_ptr] = din_o;
    sl_ptr++;
  end
  always @(posedge wr_o) if (sl_ptr == 8) begin sl_cmd = sl_in; sl_ptr = 0; end
  assign dout_i = (wr_o === 1'b0 && sl_ptr < 8) ? sl_out[sl_ptr] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_codes(input logic [7:0] prev, input logic [7:0] pins,
                              output logic [15:0] f, output bit t);
    int nbad = 0;
    f = '0;
    for (int k = 0; k < 8; k++) begin
      if (prev[k] && !pins[k])      begin f[2*k +: 2] = 2'd1; nbad++; end
      else if (!prev[k] && pins[k]) begin f[2*k +: 2] = 2'd2; nbad++; end
    end
    t = (nbad == 8);
    if (t) f = '0;
  endtask

  task automatic kick(input logic [7:0] cmd, input logic [7:0] hdiv, input logic [7:0] pins);
    pin_vec = pins;
    @(negedge clk_i);
    cmd_i = cmd; half_div_i = hdiv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic finish_frame(input logic [7:0] cmd, input logic [7:0] pins);
    logic [15:0] ef;
    bit et;
    while (!done_o) @(negedge clk_i);
    check(wr_o && sclk_o, "R6 wr/clk high at done", {wr_o, sclk_o}, 2'b11);
    check(diag_o == pins, "R5 diag", diag_o, pins);
    check(sl_cmd == cmd, "R4 command received", sl_cmd, cmd);
    if (exp_have) begin
      expect_codes(exp_prev, pins, ef, et);
      check(valid_o, "R9 valid", valid_o, 1);
      check(fault_o == ef, "R7 fault codes", fault_o, ef);
      check(thermal_o == et, "R8 thermal", thermal_o, et);
    end else begin
      check(!valid_o && fault_o == 0 && !thermal_o, "R9 first frame",
            {valid_o, thermal_o, fault_o}, 0);
    end
    exp_prev = cmd; exp_have = 1'b1;
    @(negedge clk_i);
    check(!done_o && !busy_o, "R6 done one cycle", {done_o, busy_o}, 0);
  endtask

  task automatic run_frame(input logic [7:0] cmd, input logic [7:0] hdiv,
                           input logic [7:0] pins);
    int n;
    kick(cmd, hdiv, pins);
    n = 0;
    while (sclk_o) begin @(negedge clk_i); n++; end
    meas_s = n;
    n = 0;
    while (!sclk_o) begin @(negedge clk_i); n++; end
    meas_h = n;
    finish_frame(cmd, pins);
  endtask

  task automatic t_reset();
    check(wr_o && sclk_o && !busy_o && !done_o && !valid_o, "R1 reset state",
          {wr_o, sclk_o, busy_o, done_o, valid_o}, 5'b11000);
  endtask

  task automatic t_first();
    run_frame(8'hA5, 8'd0, 8'h00);
    check(meas_s == SETUP, "R2 setup delay", meas_s, SETUP);
    check(meas_h == HMIN, "R3 clamped half period", meas_h, HMIN);
  endtask

  task automatic t_normal();
    run_frame(8'h3C, 8'd130, 8'hA5);
    check(meas_h == 130, "R3 programmed half period", meas_h, 130);
    check(fault_o == 0, "R7 all normal", fault_o, 0);
  endtask

  task automatic t_mixed();
    run_frame(8'h0F, 8'd0, 8'h3C ^ 8'h85);
    check(fault_o == 16'h8012, "R7 mixed codes", fault_o, 16'h8012);
  endtask

  task automatic t_thermal();
    run_frame(8'h55, 8'd0, 8'hF0);
    check(thermal_o == 1'b1 && fault_o == 0, "R8 all faulty", {thermal_o, fault_o}, 17'h10000);
  endtask

  task automatic t_busy_start();
    kick(8'h99, 8'd0, 8'h55);
    while (sclk_o) @(negedge clk_i);
    cmd_i = 8'h66; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    finish_frame(8'h99, 8'h55);
    repeat (20) @(negedge clk_i);
    check(!busy_o && wr_o, "R10 no second frame", {busy_o, wr_o}, 2'b01);
  endtask

  task automatic t_order();
    run_frame(8'h01, 8'd0, 8'h01);
    check(diag_o[0] == 1'b1 && diag_o[7:1] == 0, "R5 channel order", diag_o, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_first();
    t_normal();
    t_mixed();
    t_thermal();
    t_busy_start();
    t_order();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule